// File: doc/BRIEF.md
# DMA Packet Divisor Search

This block chooses how an audio DMA channel paces its transfers for one buffer period. A start strobe captures four things: the period length in bytes, a sample width flag, a threshold-mode enable and the largest FIFO threshold the port accepts. The block then reports one of three pacing modes, a transfer size in words, and a one-cycle done or error pulse.

With threshold mode off, every sample word is its own request. With threshold mode on and a period that fits the FIFO threshold, the whole period becomes one request. A longer period must be cut into equal packets that each fit the threshold. The block searches for that cut one divisor at a time. It starts at the smallest divisor that could work, which is the period divided by the threshold and rounded up. It then steps upward until a divisor splits the period exactly. That first exact divisor gives the largest packet that still fits. If only the period itself divides evenly, no usable packet exists and the block signals an error.

Each divisibility test uses a shared restoring divider that retires one quotient bit per clock. The divider also forms the starting ceiling quotient.

Top module: `pkt_div_search`

## Requirements
- R1: The period in words is the byte count shifted right by one when `wide_word` is 0 (16-bit samples), or by two when `wide_word` is 1 (32-bit samples). Any remainder is dropped.
- R2: With `thr_mode` low, the result is a done pulse with `sync_mode` = 2'b00 (per-element) and `pkt_size` = 1.
- R3: With `thr_mode` high and a word count no larger than `max_thresh`, the result is a done pulse with `sync_mode` = 2'b01 (whole-frame) and `pkt_size` equal to the word count. This includes a word count exactly equal to `max_thresh`.
- R4: With `thr_mode` high and a word count above `max_thresh`, the divisor search starts at ceil(words / max_thresh). It takes the first divisor upward that divides the word count exactly. The result is a done pulse with `sync_mode` = 2'b10 (packet) and `pkt_size` = words / divisor, which never exceeds `max_thresh`.
- R5: If the search reaches a divisor equal to the word count, `err` pulses instead of `done`, with `pkt_size` = 0 and `sync_mode` = 2'b00. This includes `max_thresh` = 1.
- R6: `busy` rises in the cycle after an accepted start and stays high until the result. `done` and `err` are never high together. Either one lasts a single cycle, during which `busy` is already low.
- R7: A start while `busy` is high is ignored: it produces no extra result and does not change the result in progress.
- R8: After reset, `busy`, `done` and `err` are low, `pkt_size` is 0 and `sync_mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| thr_mode | input | 1 | 1 = threshold pacing enabled |
| wide_word | input | 1 | 0 = 16-bit samples, 1 = 32-bit samples |
| period_bytes | input | W | Period length in bytes |
| max_thresh | input | W | Largest FIFO threshold in words |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| sync_mode | output | 2 | 00 element, 01 frame, 10 packet |
| pkt_size | output | W | Chosen transfer size in words |

## Verification
The assertions assume `max_thresh` is at least 1 whenever threshold mode is requested, because a zero threshold would mean dividing by zero. They also assume that only the values present on an accepted start matter. Every stimulus uses a nonzero threshold and keeps byte counts well inside W bits. Inputs change only at the falling edge, and a deliberately mismatched start is issued mid-search to confirm it is dropped.

// File: rtl/pkt_div_pkg.sv
package pkt_div_pkg;
  typedef enum logic [1:0] {
    SYNC_ELEM  = 2'b00,
    SYNC_FRAME = 2'b01,
    SYNC_PKT   = 2'b10
  } sync_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLASS,
    ST_CEIL,
    ST_TEST,
    ST_MOD
  } state_e;
endpackage

// File: rtl/pkt_div_wordscale.sv
module pkt_div_wordscale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         wide,
  input  logic [W-1:0] bytes_in,
  output logic [W-1:0] words
);
  localparam int SH_NARROW = 1;
  localparam int SH_WIDE   = 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else if (load) begin
      words <= wide ? (bytes_in >> SH_WIDE) : (bytes_in >> SH_NARROW);
    end
  end
endmodule

// File: rtl/pkt_div_restoring.sv
module pkt_div_restoring #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         valid,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic [W-1:0]  den_q;
  logic [W:0]    sh;
  logic [W:0]    diff;

  always_comb begin
    sh   = {rem, quo[W-1]};
    diff = sh - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        quo   <= num;
        rem   <= '0;
        den_q <= den;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        if (!diff[W]) begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= sh[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_div_search.sv
module pkt_div_search
  import pkt_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         thr_mode,
  input  logic         wide_word,
  input  logic [W-1:0] period_bytes,
  input  logic [W-1:0] max_thresh,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [1:0]   sync_mode,
  output logic [W-1:0] pkt_size
);
  state_e       state;
  logic         tm_q;
  logic [W-1:0] max_q;
  logic [W-1:0] words;
  logic [W-1:0] cand;
  logic         dv_go;
  logic [W-1:0] dv_den;
  logic         dv_valid;
  logic [W-1:0] dv_quo;
  logic [W-1:0] dv_rem;
  logic         accept;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  pkt_div_wordscale #(.W(W)) u_scale (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .wide     (wide_word),
    .bytes_in (period_bytes),
    .words    (words)
  );

  pkt_div_restoring #(.W(W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .go    (dv_go),
    .num   (words),
    .den   (dv_den),
    .valid (dv_valid),
    .quo   (dv_quo),
    .rem   (dv_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tm_q      <= 1'b0;
      max_q     <= '0;
      cand      <= '0;
      dv_go     <= 1'b0;
      dv_den    <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      sync_mode <= SYNC_ELEM;
      pkt_size  <= '0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      dv_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            tm_q  <= thr_mode;
            max_q <= max_thresh;
            state <= ST_CLASS;
          end
        end
        ST_CLASS: begin
          if (!tm_q) begin
            done      <= 1'b1;
            sync_mode <= SYNC_ELEM;
            pkt_size  <= W'(1);
            state     <= ST_IDLE;
          end else if (words <= max_q) begin
            done      <= 1'b1;
            sync_mode <= SYNC_FRAME;
            pkt_size  <= words;
            state     <= ST_IDLE;
          end else begin
            dv_den <= max_q;
            dv_go  <= 1'b1;
            state  <= ST_CEIL;
          end
        end
        ST_CEIL: begin
          if (dv_valid) begin
            cand  <= dv_quo + W'(dv_rem != '0);
            state <= ST_TEST;
          end
        end
        ST_TEST: begin
          if (cand == words) begin
            err       <= 1'b1;
            sync_mode <= SYNC_ELEM;
            pkt_size  <= '0;
            state     <= ST_IDLE;
          end else begin
            dv_den <= cand;
            dv_go  <= 1'b1;
            state  <= ST_MOD;
          end
        end
        ST_MOD: begin
          if (dv_valid) begin
            if (dv_rem == '0) begin
              done      <= 1'b1;
              sync_mode <= SYNC_PKT;
              pkt_size  <= dv_quo;
              state     <= ST_IDLE;
            end else begin
              cand  <= cand + 1'b1;
              state <= ST_TEST;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_div_search_chk.sv
module pkt_div_search_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         thr_mode,
  input logic [W-1:0] max_thresh,
  input logic         busy,
  input logic         done,
  input logic         err,
  input logic [1:0]   sync_mode,
  input logic [W-1:0] pkt_size
);
  logic         cap_tm;
  logic [W-1:0] cap_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_tm  <= 1'b0;
      cap_max <= '0;
    end else if (start && !busy) begin
      cap_tm  <= thr_mode;
      cap_max <= max_thresh;
    end
  end

  // R6
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  // R6
  pulse_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (!busy && $past(busy)));

  // R6
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R2
  elem_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_tm) |-> (sync_mode == 2'b00 && pkt_size == W'(1)));

  // R4
  fits_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_tm) |-> (pkt_size <= cap_max && sync_mode != 2'b00));

  // R5
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (pkt_size == '0 && cap_tm));
endmodule

bind pkt_div_search pkt_div_search_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .thr_mode   (thr_mode),
  .max_thresh (max_thresh),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .sync_mode  (sync_mode),
  .pkt_size   (pkt_size)
);

// File: tb/pkt_div_search_bench.sv
module pkt_div_search_bench;
  localparam int W = 16;

  typedef struct {
    bit           is_err;
    logic [1:0]   mode;
    logic [W-1:0] pkt;
    string        rq;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         thr_mode = 1'b0;
  logic         wide_word = 1'b0;
  logic [W-1:0] period_bytes = '0;
  logic [W-1:0] max_thresh = '0;
  logic         busy;
  logic         done;
  logic         err;
  logic [1:0]   sync_mode;
  logic [W-1:0] pkt_size;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  pkt_div_search #(.W(W)) u_pkt_div_search (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .thr_mode     (thr_mode),
    .wide_word    (wide_word),
    .period_bytes (period_bytes),
    .max_thresh   (max_thresh),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .sync_mode    (sync_mode),
    .pkt_size     (pkt_size)
  );

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] pb, input logic wd,
                                 input logic tm, input logic [W-1:0] mx);
    exp_t e;
    int   w;
    int   d;
    w = wd ? (int'(pb) / 4) : (int'(pb) / 2);
    e.is_err = 1'b0;
    if (!tm) begin
      e.mode = 2'b00;
      e.pkt  = W'(1);
    end else if (w <= int'(mx)) begin
      e.mode = 2'b01;
      e.pkt  = W'(w);
    end else begin
      d = (w + int'(mx) - 1) / int'(mx);
      while ((w % d) != 0 && d < w) d++;
      if (d == w) begin
        e.is_err = 1'b1;
        e.mode   = 2'b00;
        e.pkt    = '0;
      end else begin
        e.mode = 2'b10;
        e.pkt  = W'(w / d);
      end
    end
    return e;
  endfunction

  task automatic run(input logic [W-1:0] pb, input logic wd, input logic tm,
                     input logic [W-1:0] mx, input string rq);
    exp_t e;
    e    = model(pb, wd, tm, mx);
    e.rq = rq;
    exp_q.push_back(e);
    @(negedge clk);
    period_bytes = pb;
    wide_word    = wd;
    thr_mode     = tm;
    max_thresh   = mx;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops one expectation per result pulse.
  always @(negedge clk) begin
    if (!rst && (done || err)) begin
      exp_t e;
      check(!(done && err), "R6 exclusive pulses", int'({done, err}), 1);
      check(!busy, "R6 busy low at result", int'(busy), 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", int'(pkt_size), -1);
      end else begin
        e = exp_q.pop_front();
        check(err == e.is_err, {e.rq, " err flag"}, int'(err), int'(e.is_err));
        check(sync_mode == e.mode, {e.rq, " sync mode"}, int'(sync_mode), int'(e.mode));
        check(pkt_size == e.pkt, {e.rq, " size"}, int'(pkt_size), int'(e.pkt));
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset values
    check(!busy && !done && !err, "R8 flags", int'({busy, done, err}), 0);
    check(pkt_size == '0, "R8 size", int'(pkt_size), 0);
    check(sync_mode == 2'b00, "R8 mode", int'(sync_mode), 0);

    run(16'd200, 1'b0, 1'b0, 16'd8,  "R2 element");
    run(16'd40,  1'b0, 1'b1, 16'd32, "R3 frame 16-bit");
    run(16'd10,  1'b1, 1'b1, 16'd32, "R1 truncate 32-bit");
    run(16'd11,  1'b0, 1'b1, 16'd32, "R1 truncate 16-bit");
    run(16'd128, 1'b1, 1'b1, 16'd32, "R3 frame equal");
    run(16'd192, 1'b0, 1'b1, 16'd40, "R4 packet exact ceil");
    run(16'd196, 1'b0, 1'b1, 16'd40, "R4 packet searched");
    run(16'd32,  1'b1, 1'b1, 16'd4,  "R4 packet 32-bit");
    run(16'd194, 1'b0, 1'b1, 16'd40, "R5 prime period");
    run(16'd10,  1'b0, 1'b1, 16'd1,  "R5 unit threshold");

    for (int pb = 200; pb <= 260; pb += 6) begin
      run(W'(pb), pb[1], 1'b1, 16'd17, "R4 sweep");
    end

    // R7: a second start during the search must be dropped
    begin
      exp_t e;
      e    = model(16'd194, 1'b0, 1'b1, 16'd40);
      e.rq = "R7 busy start ignored";
      exp_q.push_back(e);
      @(negedge clk);
      period_bytes = 16'd194;
      wide_word    = 1'b0;
      thr_mode     = 1'b1;
      max_thresh   = 16'd40;
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      period_bytes = 16'd40;
      max_thresh   = 16'd64;
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(!busy, "R7 stays idle", int'(busy), 0);
      check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule